// File: doc/BRIEF.md
# Security-Banked Special Register Access Unit

This unit keeps two copies of a small core's special registers: one copy for the secure state and one for the non-secure state. The registers are the main stack pointer, the process stack pointer, the interrupt mask bit, the base priority byte, the fault mask bit and the control field. Move-to-special and move-from-special operations name a register with an 8-bit selector. Plain selectors reach the copy that belongs to the current state. A group of alias selectors, with bit 7 set, lets secure code reach the non-secure copy directly.

Side inputs give the current security state, the privilege level, handler or thread mode, and whether the security extension is present. These inputs gate every access. A read returns a 32-bit value and is combinational. A write happens on the rising clock edge when the strobe is high, and it changes at most one register. One alias stands for whichever non-secure stack pointer is active. It resolves through the non-secure control SPSEL bit and through the thread or handler mode.

Top module: `banked_sreg_unit`

## Requirements
- R1: After an active-low synchronous reset, every banked register is zero, so every selector reads zero.
- R2: With the extension present, secure privileged code reads and writes the non-secure copy through these aliases: 0x88 main SP, 0x89 process SP, 0x90 interrupt mask, 0x91 base priority, 0x93 fault mask, 0x94 control.
- R3: Plain selectors 0x08 main SP, 0x09 process SP, 0x10 interrupt mask, 0x11 base priority, 0x13 fault mask and 0x14 (decimal 20) control reach the current state's copy. The secure copy is used only when cur_secure and sec_ext_en are both 1.
- R4: In the non-secure state, any read through an alias returns zero, and any write through an alias has no effect.
- R5: Unprivileged code may read selector 0x14. Unprivileged secure code may read alias 0x94. Both checks are made before the unprivileged rule of R6.
- R6: An unprivileged read of any other selector returns zero.
- R7: An unprivileged write to any selector changes no register.
- R8: Writes keep only part of the data. The interrupt mask and the fault mask keep bit 0. The base priority keeps bits 7:0. The control field keeps bits 1:0, where bit 1 is SPSEL. The stack pointers keep all 32 bits. Reads zero-extend.
- R9: Alias 0x98 reaches the non-secure process SP when the core is in thread mode and the non-secure SPSEL bit is 1. Otherwise it reaches the non-secure main SP. Reads and writes use the same choice. Aliases 0x88 and 0x89 ignore the mode and SPSEL.
- R10: With sec_ext_en low, the aliases fall through to the plain decode. They therefore read zero and ignore writes. Alias 0x94 also reads zero.
- R11: Selectors outside R2, R3 and R9 read zero and ignore writes.
- R12: rd_data follows sel combinationally. A write becomes visible only after the clock edge, and it changes only its one target register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_ext_en | input | 1 | Security extension present |
| cur_secure | input | 1 | Core is in the secure state |
| privileged | input | 1 | Core is privileged |
| handler_mode | input | 1 | Core is in handler mode (0 = thread) |
| sel | input | 8 | Register selector |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write value |
| rd_data | output | 32 | Read value for sel |

## Verification
A wrong internal value stays hidden until some selector reads it back. A wrong value written through an alias, a lost mask, or a write sent to the wrong bank or the wrong stack pointer therefore shows up at the first later read of that register, one cycle after the write at the earliest. A failure of the gating shows up at once, because reads are combinational: a read that should be zero is not. A write that was supposed to be ignored leaves a changed value, and the next legitimate read of that register shows it. The bench reads back frequently from a mix of states, so such errors surface within a few operations.

// File: rtl/banked_sreg_unit.sv
module banked_sreg_unit #(
  parameter int DATA_W = 32,
  parameter int PRI_W  = 8,
  parameter int CTRL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_ext_en,
  input  logic              cur_secure,
  input  logic              privileged,
  input  logic              handler_mode,
  input  logic [7:0]        sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int NS = 0;
  localparam int SPSEL_BIT = 1;

  localparam logic [7:0] P_MSP  = 8'h08, P_PSP  = 8'h09, P_PMSK = 8'h10,
                         P_BPRI = 8'h11, P_FMSK = 8'h13, P_CTRL = 8'h14;
  localparam logic [7:0] A_MSP  = 8'h88, A_PSP  = 8'h89, A_PMSK = 8'h90,
                         A_BPRI = 8'h91, A_FMSK = 8'h93, A_CTRL = 8'h94,
                         A_SP   = 8'h98;

  logic [DATA_W-1:0] msp_q  [2];
  logic [DATA_W-1:0] psp_q  [2];
  logic              pmsk_q [2];
  logic [PRI_W-1:0]  bpri_q [2];
  logic              fmsk_q [2];
  logic [CTRL_W-1:0] ctrl_q [2];

  wire sec_eff   = sec_ext_en & cur_secure;
  wire bank      = sec_eff;
  wire sp_to_psp = ~handler_mode & ctrl_q[NS][SPSEL_BIT];
  wire wr_go     = wr_en & privileged;

  logic alias_sel;
  always_comb begin
    alias_sel = 1'b0;
    if (sec_ext_en)
      case (sel)
        A_MSP, A_PSP, A_PMSK, A_BPRI, A_FMSK, A_SP: alias_sel = 1'b1;
        default: alias_sel = 1'b0;
      endcase
  end

  always_comb begin
    rd_data = '0;
    if (sel == A_CTRL) begin
      if (sec_eff) rd_data = DATA_W'(ctrl_q[NS]);
    end else if (sel == P_CTRL) begin
      rd_data = DATA_W'(ctrl_q[bank]);
    end else if (privileged) begin
      if (alias_sel) begin
        if (sec_eff)
          case (sel)
            A_MSP:   rd_data = msp_q[NS];
            A_PSP:   rd_data = psp_q[NS];
            A_PMSK:  rd_data = DATA_W'(pmsk_q[NS]);
            A_BPRI:  rd_data = DATA_W'(bpri_q[NS]);
            A_FMSK:  rd_data = DATA_W'(fmsk_q[NS]);
            A_SP:    rd_data = sp_to_psp ? psp_q[NS] : msp_q[NS];
            default: rd_data = '0;
          endcase
      end else begin
        case (sel)
          P_MSP:   rd_data = msp_q[bank];
          P_PSP:   rd_data = psp_q[bank];
          P_PMSK:  rd_data = DATA_W'(pmsk_q[bank]);
          P_BPRI:  rd_data = DATA_W'(bpri_q[bank]);
          P_FMSK:  rd_data = DATA_W'(fmsk_q[bank]);
          default: rd_data = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++) begin
        msp_q[b]  <= '0;
        psp_q[b]  <= '0;
        pmsk_q[b] <= 1'b0;
        bpri_q[b] <= '0;
        fmsk_q[b] <= 1'b0;
        ctrl_q[b] <= '0;
      end
    end else if (wr_go) begin
      if (sel == A_CTRL) begin
        if (sec_eff) ctrl_q[NS] <= wr_data[CTRL_W-1:0];
      end else if (alias_sel) begin
        if (sec_eff)
          case (sel)
            A_MSP:  msp_q[NS]  <= wr_data;
            A_PSP:  psp_q[NS]  <= wr_data;
            A_PMSK: pmsk_q[NS] <= wr_data[0];
            A_BPRI: bpri_q[NS] <= wr_data[PRI_W-1:0];
            A_FMSK: fmsk_q[NS] <= wr_data[0];
            A_SP: begin
              if (sp_to_psp) psp_q[NS] <= wr_data;
              else           msp_q[NS] <= wr_data;
            end
            default: ;
          endcase
      end else begin
        case (sel)
          P_MSP:  msp_q[bank]  <= wr_data;
          P_PSP:  psp_q[bank]  <= wr_data;
          P_PMSK: pmsk_q[bank] <= wr_data[0];
          P_BPRI: bpri_q[bank] <= wr_data[PRI_W-1:0];
          P_FMSK: fmsk_q[bank] <= wr_data[0];
          P_CTRL: ctrl_q[bank] <= wr_data[CTRL_W-1:0];
          default: ;
        endcase
      end
    end
  end

  wire [2*(2*DATA_W+PRI_W+CTRL_W+2)-1:0] state_flat =
    {msp_q[0], msp_q[1], psp_q[0], psp_q[1], pmsk_q[0], pmsk_q[1],
     bpri_q[0], bpri_q[1], fmsk_q[0], fmsk_q[1], ctrl_q[0], ctrl_q[1]};

  // R7
  unpriv_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !privileged) |=> $stable(state_flat));

  // R4
  ns_alias_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur_secure && sel[7]) |-> rd_data == '0);

  // R6
  unpriv_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!privileged && sel != P_CTRL && sel != A_CTRL) |-> rd_data == '0);

  // R9
  sp_alias_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && privileged && sec_ext_en && cur_secure && sel == A_SP &&
     !handler_mode && ctrl_q[NS][SPSEL_BIT]) |=> $stable(msp_q[NS]));

  // R10
  noext_alias_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sec_ext_en && sel[7]) |=> $stable(state_flat));
endmodule

// File: tb/banked_sreg_unit_test.sv
module banked_sreg_unit_test;
  logic clk = 0, rst_n = 0;
  logic sec_ext_en = 1, cur_secure = 1, privileged = 1, handler_mode = 0;
  logic [7:0] sel = 0;
  logic wr_en = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  banked_sreg_unit uut (.clk(clk), .rst_n(rst_n), .sec_ext_en(sec_ext_en),
    .cur_secure(cur_secure), .privileged(privileged), .handler_mode(handler_mode),
    .sel(sel), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data));

  logic [31:0] m_msp[2], m_psp[2];
  logic        m_pm[2], m_fm[2];
  logic [7:0]  m_bp[2];
  logic [1:0]  m_ct[2];

  function automatic bit is_alias(logic [7:0] s);
    return s == 8'h88 || s == 8'h89 || s == 8'h90 || s == 8'h91 ||
           s == 8'h93 || s == 8'h98;
  endfunction

  function automatic logic [31:0] ref_rd(logic [7:0] s, bit sec, bit pr, bit hd, bit ext);
    bit b = sec & ext;
    if (s == 8'h94) return b ? {30'd0, m_ct[0]} : 32'd0;
    if (s == 8'h14) return {30'd0, m_ct[b]};
    if (!pr) return 0;
    if (ext && is_alias(s)) begin
      if (!b) return 0;
      case (s)
        8'h88: return m_msp[0];
        8'h89: return m_psp[0];
        8'h90: return {31'd0, m_pm[0]};
        8'h91: return {24'd0, m_bp[0]};
        8'h93: return {31'd0, m_fm[0]};
        default: return (!hd && m_ct[0][1]) ? m_psp[0] : m_msp[0];
      endcase
    end
    case (s)
      8'h08: return m_msp[b];
      8'h09: return m_psp[b];
      8'h10: return {31'd0, m_pm[b]};
      8'h11: return {24'd0, m_bp[b]};
      8'h13: return {31'd0, m_fm[b]};
      default: return 0;
    endcase
  endfunction

  task automatic ref_wr(logic [7:0] s, bit sec, bit pr, bit hd, bit ext, logic [31:0] d);
    bit b = sec & ext;
    if (!pr) return;
    if (s == 8'h94) begin if (b) m_ct[0] = d[1:0]; return; end
    if (ext && is_alias(s)) begin
      if (!b) return;
      case (s)
        8'h88: m_msp[0] = d;
        8'h89: m_psp[0] = d;
        8'h90: m_pm[0] = d[0];
        8'h91: m_bp[0] = d[7:0];
        8'h93: m_fm[0] = d[0];
        default: if (!hd && m_ct[0][1]) m_psp[0] = d; else m_msp[0] = d;
      endcase
      return;
    end
    case (s)
      8'h08: m_msp[b] = d;
      8'h09: m_psp[b] = d;
      8'h10: m_pm[b] = d[0];
      8'h11: m_bp[b] = d[7:0];
      8'h13: m_fm[b] = d[0];
      8'h14: m_ct[b] = d[1:0];
      default: ;
    endcase
  endtask

  function automatic string tag_of(logic [7:0] s, bit sec, bit pr, bit ext);
    if (s == 8'h94 || (s == 8'h14 && !pr)) return "R5";
    if (!pr) return "R6";
    if (s[7] && !ext) return "R10";
    if (s[7] && !sec) return "R4";
    if (s == 8'h98) return "R9";
    if (is_alias(s)) return "R2";
    if (s == 8'h08 || s == 8'h09 || s == 8'h10 || s == 8'h11 || s == 8'h13 || s == 8'h14)
      return "R3";
    return "R11";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s sel=%h actual=%h expected=%h", tag, sel, act, exp);
    end
  endtask

  task automatic op(bit sec, bit pr, bit hd, bit ext, logic [7:0] s, bit we,
                    logic [31:0] d, string tag = "");
    @(negedge clk);
    cur_secure = sec; privileged = pr; handler_mode = hd; sec_ext_en = ext;
    sel = s; wr_en = we; wr_data = d;
    #1;
    check(tag == "" ? tag_of(s, sec, pr, ext) : tag, rd_data, ref_rd(s, sec, pr, hd, ext));
    @(posedge clk);
    if (we) ref_wr(s, sec, pr, hd, ext, d);
    #1 wr_en = 0;
  endtask

  task automatic peek(bit sec, bit pr, bit hd, bit ext, logic [7:0] s,
                      logic [31:0] exp, string tag);
    @(negedge clk);
    cur_secure = sec; privileged = pr; handler_mode = hd; sec_ext_en = ext;
    sel = s; wr_en = 0;
    #1 check(tag, rd_data, exp);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] list [13] = '{8'h08, 8'h09, 8'h10, 8'h11, 8'h13, 8'h14,
      8'h88, 8'h89, 8'h90, 8'h91, 8'h93, 8'h94, 8'h98};
    for (int b = 0; b < 2; b++) begin
      m_msp[b] = 0; m_psp[b] = 0; m_pm[b] = 0; m_fm[b] = 0; m_bp[b] = 0; m_ct[b] = 0;
    end
    void'($urandom(32'd7321));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    for (int i = 0; i < 13; i++) peek(1, 1, 0, 1, list[i], 32'd0, "R1");

    // R8 masking through aliases
    op(1, 1, 0, 1, 8'h91, 1, 32'hFFFF_FFA5);
    peek(1, 1, 0, 1, 8'h91, 32'h0000_00A5, "R8");
    op(1, 1, 0, 1, 8'h90, 1, 32'hFFFF_FFFE);
    peek(1, 1, 0, 1, 8'h90, 32'd0, "R8");
    op(1, 1, 0, 1, 8'h93, 1, 32'd3);
    peek(1, 1, 0, 1, 8'h93, 32'd1, "R8");
    op(1, 1, 0, 1, 8'h94, 1, 32'hFF);
    peek(1, 1, 0, 1, 8'h94, 32'd3, "R8");

    // R9 current-SP alias routing (NS SPSEL now 1)
    op(1, 1, 0, 1, 8'h98, 1, 32'h1111_2220);
    peek(1, 1, 0, 1, 8'h89, 32'h1111_2220, "R9");
    peek(1, 1, 0, 1, 8'h88, 32'd0, "R9");
    op(1, 1, 1, 1, 8'h98, 1, 32'h0000_3330);
    peek(1, 1, 1, 1, 8'h88, 32'h0000_3330, "R9");
    peek(1, 1, 0, 1, 8'h98, 32'h1111_2220, "R9");
    peek(1, 1, 1, 1, 8'h98, 32'h0000_3330, "R9");

    // R3 non-secure state sees its own copy via plain selectors
    peek(0, 1, 0, 1, 8'h08, 32'h0000_3330, "R3");
    peek(0, 1, 0, 1, 8'h11, 32'h0000_00A5, "R3");
    peek(1, 1, 0, 1, 8'h08, 32'd0, "R3");

    // R4 alias from non-secure state
    peek(0, 1, 0, 1, 8'h89, 32'd0, "R4");
    op(0, 1, 0, 1, 8'h89, 1, 32'hDEAD_BEEF);
    peek(1, 1, 0, 1, 8'h89, 32'h1111_2220, "R4");

    // R5 / R6 unprivileged reads
    peek(1, 0, 0, 1, 8'h94, 32'd3, "R5");
    peek(0, 0, 0, 1, 8'h94, 32'd0, "R5");
    peek(0, 0, 0, 1, 8'h14, 32'd3, "R5");
    peek(1, 0, 0, 1, 8'h91, 32'd0, "R6");

    // R7 unprivileged write ignored
    op(1, 0, 0, 1, 8'h91, 1, 32'h0000_0011);
    peek(1, 1, 0, 1, 8'h91, 32'h0000_00A5, "R7");

    // R12 read shows old value before the edge, single target
    op(1, 1, 0, 1, 8'h08, 1, 32'h5555_0000, "R12");
    peek(1, 1, 0, 1, 8'h08, 32'h5555_0000, "R12");
    peek(1, 1, 0, 1, 8'h09, 32'd0, "R12");

    // R11 unknown selector
    op(1, 1, 0, 1, 8'h42, 1, 32'hFFFF_FFFF);
    peek(1, 1, 0, 1, 8'h42, 32'd0, "R11");

    // R10 extension absent
    peek(1, 1, 0, 0, 8'h88, 32'd0, "R10");
    op(1, 1, 0, 0, 8'h88, 1, 32'h7777_7777);
    peek(1, 1, 1, 1, 8'h88, 32'h0000_3330, "R10");
    peek(1, 1, 0, 0, 8'h94, 32'd0, "R10");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int k = $urandom % 15;
      logic [7:0] s = (k < 13) ? list[k] : 8'($urandom);
      logic [31:0] d = $urandom;
      op(($urandom % 4) != 0, ($urandom % 5) != 0, $urandom % 2,
         ($urandom % 6) != 0, s, ($urandom % 2) == 1, d);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule